// File: doc/BRIEF.md
# Packed Quotient-Remainder Divider

A multi-cycle integer divider with two operand shapes. The narrow shape divides a 16-bit dividend by an 8-bit divisor. The wide shape divides a 32-bit dividend by a 16-bit divisor. Each shape can treat its operands as signed or unsigned. The quotient and the remainder come back together in one result word. The remainder sits in the upper half of the destination width and the quotient in the lower half.

A one-cycle `start_i` pulse captures the operands, the shape select and the sign select. The unit then computes the magnitudes, runs a restoring division that produces one quotient bit per clock, and applies the sign corrections in a final cycle. When the result is ready it raises `done_o` for one cycle, together with the packed word, a negative flag, a zero flag and a divide-by-zero flag.

Top module: `pqr_divider`

## Requirements
- R1: Narrow unsigned (`wide_i`=0, `signed_i`=0): `result_o[7:0]` = quotient modulo 256, `result_o[15:8]` = remainder, `result_o[31:16]` = 0. Only `dividend_i[15:0]` and `divisor_i[7:0]` are used.
- R2: Wide unsigned (`wide_i`=1, `signed_i`=0): `result_o[15:0]` = quotient modulo 65536 and `result_o[31:16]` = remainder.
- R3: Narrow signed: `dividend_i[15:0]` is read as a two's-complement value. `divisor_i[7:0]` is sign-extended from bit 7. `dividend_i[31:16]` and `divisor_i[15:8]` have no effect.
- R4: Wide signed: `dividend_i` is a 32-bit two's-complement value and `divisor_i` is sign-extended from bit 15.
- R5: Signed division truncates toward zero. The remainder is zero or has the sign of the dividend, and quotient × divisor + remainder = dividend.
- R6: `neg_o` equals the top bit of the packed quotient field: bit 7 in narrow mode, bit 15 in wide mode.
- R7: `zero_o` is 1 exactly when the packed quotient field is all zeros.
- R8: When the divisor, after sign extension, is zero:
  - `dz_o`=1 and `done_o` rises on the edge that accepts the start.
  - `result_o`, `neg_o` and `zero_o` keep their previous values.
  - A later successful division clears `dz_o`.
- R9: For a nonzero divisor, `done_o` is high for exactly one cycle. It rises on the 17th clock edge after the accepting edge in narrow mode and on the 33rd in wide mode. `busy_o` is high from the accepting edge until `done_o` rises.
- R10: `start_i` is ignored while `busy_o` is high. The running division finishes on time with its own operands.
- R11: After reset, `result_o`=0 and `done_o`, `busy_o`, `neg_o`, `zero_o` and `dz_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| dividend_i | input | 32 | Dividend (low 16 bits in narrow mode) |
| divisor_i | input | 16 | Divisor (low 8 bits in narrow mode) |
| wide_i | input | 1 | 1: 32-by-16, 0: 16-by-8 |
| signed_i | input | 1 | 1: two's-complement operands |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Remainder in upper half, quotient in lower half |
| neg_o | output | 1 | Quotient field sign bit |
| zero_o | output | 1 | Quotient field is zero |
| dz_o | output | 1 | Last operation had a zero divisor |

## Verification
The bench runs the four operand-sign combinations with both shapes. These cases separate a correct post-correction from errors that flip the sign of the wrong field, or that floor instead of truncating. Narrow cases carry junk in the unused upper operand bits, which shows whether sign extension starts from bit 7 or bit 15. The bench also drives extreme operands: the most negative dividend over -1, a quotient that overflows its field, a divisor larger than the dividend, and all-ones unsigned values. These cases exercise field truncation, the 17-bit partial remainder and the zero flag. A zero divisor, and a start pulse injected mid-run, check that results are held and that stray requests are ignored.

// File: rtl/pqr_pkg.sv
package pqr_pkg;
  localparam int unsigned DVD_W = 32;
  localparam int unsigned DVS_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } pqr_state_e;
endpackage

// File: rtl/pqr_operand_prep.sv
module pqr_operand_prep #(
  parameter int unsigned DVD_W = pqr_pkg::DVD_W,
  parameter int unsigned DVS_W = pqr_pkg::DVS_W
) (
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  input  logic             wide_i,
  input  logic             signed_i,
  output logic [DVD_W-1:0] dvd_mag_o,
  output logic [DVS_W-1:0] dvs_mag_o,
  output logic             quo_neg_o,
  output logic             rem_neg_o,
  output logic             dvs_zero_o
);
  localparam int unsigned NDVD_W = DVD_W / 2;
  localparam int unsigned NDVS_W = DVS_W / 2;

  logic [DVD_W-1:0] dvd_ext;
  logic [DVS_W-1:0] dvs_ext;
  logic             dvd_neg, dvs_neg;

  always_comb begin
    if (wide_i) begin
      dvd_ext = dividend_i;
      dvs_ext = divisor_i;
    end else begin
      dvd_ext = {{(DVD_W-NDVD_W){signed_i & dividend_i[NDVD_W-1]}}, dividend_i[NDVD_W-1:0]};
      dvs_ext = {{(DVS_W-NDVS_W){signed_i & divisor_i[NDVS_W-1]}}, divisor_i[NDVS_W-1:0]};
    end
    dvd_neg    = signed_i & dvd_ext[DVD_W-1];
    dvs_neg    = signed_i & dvs_ext[DVS_W-1];
    dvd_mag_o  = dvd_neg ? (~dvd_ext + 1'b1) : dvd_ext;
    dvs_mag_o  = dvs_neg ? (~dvs_ext + 1'b1) : dvs_ext;
    quo_neg_o  = dvd_neg ^ dvs_neg;
    rem_neg_o  = dvd_neg;
    dvs_zero_o = (dvs_ext == '0);
  end
endmodule

// File: rtl/pqr_restoring_core.sv
module pqr_restoring_core #(
  parameter int unsigned DVD_W = pqr_pkg::DVD_W,
  parameter int unsigned DVS_W = pqr_pkg::DVS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             wide_i,
  input  logic [DVD_W-1:0] dvd_mag_i,
  input  logic [DVS_W-1:0] dvs_mag_i,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W:0]   rem_o,
  output logic             last_o
);
  localparam int unsigned NDVD_W = DVD_W / 2;
  localparam int unsigned CNT_W  = $clog2(DVD_W + 1);
  localparam int unsigned REM_W  = DVS_W + 1;

  logic [DVD_W-1:0] quo_q;
  logic [REM_W-1:0] rem_q;
  logic [DVS_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q;

  logic [REM_W-1:0] shifted;
  logic [REM_W:0]   diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q[DVS_W-1:0], quo_q[DVD_W-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs_q};
    fits    = ~diff[REM_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      // narrow dividend is left-aligned so only half the steps are needed
      quo_q <= wide_i ? dvd_mag_i : {dvd_mag_i[NDVD_W-1:0], {(DVD_W-NDVD_W){1'b0}}};
      rem_q <= '0;
      dvs_q <= dvs_mag_i;
      cnt_q <= wide_i ? CNT_W'(DVD_W) : CNT_W'(NDVD_W);
    end else if (step_i && cnt_q != '0) begin
      quo_q <= {quo_q[DVD_W-2:0], fits};
      rem_q <= fits ? diff[REM_W-1:0] : shifted;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/pqr_result_pack.sv
module pqr_result_pack #(
  parameter int unsigned DVD_W = pqr_pkg::DVD_W,
  parameter int unsigned DVS_W = pqr_pkg::DVS_W
) (
  input  logic [DVD_W-1:0] quo_mag_i,
  input  logic [DVS_W:0]   rem_mag_i,
  input  logic             quo_neg_i,
  input  logic             rem_neg_i,
  input  logic             wide_i,
  output logic [DVD_W-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o
);
  localparam int unsigned HALF_W  = DVD_W / 2;
  localparam int unsigned NHALF_W = DVS_W / 2;

  logic [DVD_W-1:0] quo_s;
  logic [DVS_W:0]   rem_s;

  always_comb begin
    quo_s = quo_neg_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    rem_s = rem_neg_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    if (wide_i) begin
      result_o = {rem_s[HALF_W-1:0], quo_s[HALF_W-1:0]};
      neg_o    = quo_s[HALF_W-1];
      zero_o   = (quo_s[HALF_W-1:0] == '0);
    end else begin
      result_o = {{(DVD_W-2*NHALF_W){1'b0}}, rem_s[NHALF_W-1:0], quo_s[NHALF_W-1:0]};
      neg_o    = quo_s[NHALF_W-1];
      zero_o   = (quo_s[NHALF_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/pqr_divider.sv
module pqr_divider #(
  parameter int unsigned DVD_W = pqr_pkg::DVD_W,
  parameter int unsigned DVS_W = pqr_pkg::DVS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  input  logic             wide_i,
  input  logic             signed_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             dz_o
);
  import pqr_pkg::*;

  pqr_state_e       state_q;
  logic             wide_q, quo_neg_q, rem_neg_q;
  logic             done_q, dz_q, neg_q, zero_q;
  logic [DVD_W-1:0] result_q;

  logic [DVD_W-1:0] dvd_mag;
  logic [DVS_W-1:0] dvs_mag;
  logic             quo_neg, rem_neg, dvs_zero;
  logic [DVD_W-1:0] core_quo;
  logic [DVS_W:0]   core_rem;
  logic             core_last;
  logic [DVD_W-1:0] pack_res;
  logic             pack_neg, pack_zero;
  logic             accept, load;

  assign accept = (state_q == ST_IDLE) && start_i;
  assign load   = accept && !dvs_zero;

  pqr_operand_prep #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_prep (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .wide_i     (wide_i),
    .signed_i   (signed_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .quo_neg_o  (quo_neg),
    .rem_neg_o  (rem_neg),
    .dvs_zero_o (dvs_zero)
  );

  pqr_restoring_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .step_i    (state_q == ST_RUN),
    .wide_i    (wide_i),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .quo_o     (core_quo),
    .rem_o     (core_rem),
    .last_o    (core_last)
  );

  pqr_result_pack #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_pack (
    .quo_mag_i (core_quo),
    .rem_mag_i (core_rem),
    .quo_neg_i (quo_neg_q),
    .rem_neg_i (rem_neg_q),
    .wide_i    (wide_q),
    .result_o  (pack_res),
    .neg_o     (pack_neg),
    .zero_o    (pack_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      wide_q    <= 1'b0;
      quo_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
      done_q    <= 1'b0;
      dz_q      <= 1'b0;
      neg_q     <= 1'b0;
      zero_q    <= 1'b0;
      result_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            wide_q    <= wide_i;
            quo_neg_q <= quo_neg;
            rem_neg_q <= rem_neg;
            if (dvs_zero) begin
              done_q <= 1'b1;
              dz_q   <= 1'b1;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_last) state_q <= ST_FIX;
        end
        ST_FIX: begin
          result_q <= pack_res;
          neg_q    <= pack_neg;
          zero_q   <= pack_zero;
          dz_q     <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
  assign neg_o    = neg_q;
  assign zero_o   = zero_q;
  assign dz_o     = dz_q;
endmodule

// File: rtl/pqr_divider_chk.sv
module pqr_divider_chk #(
  parameter int unsigned DVD_W = pqr_pkg::DVD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [DVD_W-1:0] result_o,
  input logic             neg_o,
  input logic             zero_o,
  input logic             dz_o,
  input logic             wide_q
);
  localparam int unsigned HALF_W = DVD_W / 2;
  localparam int unsigned QTR_W  = DVD_W / 4;

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_runs_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_dz_holds_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dz_o) |-> ($stable(result_o) && $stable(neg_o) && $stable(zero_o)));

  p_narrow_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dz_o && !wide_q) |-> (result_o[DVD_W-1:HALF_W] == '0));

  p_neg_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dz_o) |-> (neg_o == (wide_q ? result_o[HALF_W-1] : result_o[QTR_W-1])));

  p_zero_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !dz_o) |->
      (zero_o == (wide_q ? (result_o[HALF_W-1:0] == '0) : (result_o[QTR_W-1:0] == '0))));
endmodule

bind pqr_divider pqr_divider_chk #(.DVD_W(DVD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .neg_o    (neg_o),
  .zero_o   (zero_o),
  .dz_o     (dz_o),
  .wide_q   (wide_q)
);

// File: tb/pqr_divider_bench.sv
module pqr_divider_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic        wide_i = 1'b0;
  logic        signed_i = 1'b0;
  logic        busy_o, done_o, neg_o, zero_o, dz_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] prev_res = '0;
  logic        prev_neg = 1'b0;
  logic        prev_zero = 1'b0;

  always #5 clk_i = ~clk_i;

  pqr_divider u_pqr_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .wide_i(wide_i), .signed_i(signed_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .neg_o(neg_o), .zero_o(zero_o), .dz_o(dz_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference: SV / and % truncate toward zero, % takes the dividend's sign
  task automatic run_div(input logic [31:0] dvd, input logic [15:0] dvs,
                         input bit wide, input bit sgn, input bit poke,
                         input string req);
    longint a, b, q, r;
    logic [31:0] exp_res;
    bit exp_neg, exp_zero, exp_dz;
    int lat, exp_lat;
    if (wide) begin
      a = sgn ? longint'($signed(dvd)) : longint'(dvd);
      b = sgn ? longint'($signed(dvs)) : longint'(dvs);
    end else begin
      a = sgn ? longint'($signed(dvd[15:0])) : longint'(dvd[15:0]);
      b = sgn ? longint'($signed(dvs[7:0])) : longint'(dvs[7:0]);
    end
    exp_dz = (b == 0);
    if (exp_dz) begin
      exp_res = prev_res; exp_neg = prev_neg; exp_zero = prev_zero; exp_lat = 1;
    end else begin
      q = a / b;
      r = a % b;
      if (wide) begin
        exp_res  = {r[15:0], q[15:0]};
        exp_neg  = q[15];
        exp_zero = (q[15:0] == 16'h0);
        exp_lat  = 34;
      end else begin
        exp_res  = {16'h0, r[7:0], q[7:0]};
        exp_neg  = q[7];
        exp_zero = (q[7:0] == 8'h0);
        exp_lat  = 18;
      end
    end
    @(negedge clk_i);
    dividend_i = dvd; divisor_i = dvs; wide_i = wide; signed_i = sgn; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 100) begin
      if (poke && lat == 5) begin
        dividend_i = 32'h0000_0007; divisor_i = 16'h0001; wide_i = ~wide; start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    chk(lat == exp_lat, {req, " latency R9"}, lat, exp_lat);
    chk(result_o == exp_res, {req, " result"}, result_o, exp_res);
    chk(neg_o == exp_neg, {req, " neg R6"}, neg_o, exp_neg);
    chk(zero_o == exp_zero, {req, " zero R7"}, zero_o, exp_zero);
    chk(dz_o == exp_dz, {req, " dz R8"}, dz_o, exp_dz);
    @(negedge clk_i);
    chk(!done_o, {req, " done pulse R9"}, done_o, 0);
    prev_res = result_o; prev_neg = neg_o; prev_zero = zero_o;
  endtask

  task automatic t_reset();
    chk(result_o == 32'h0, "R11 result", result_o, 0);
    chk({done_o, busy_o, neg_o, zero_o, dz_o} == 5'b0, "R11 flags",
        {done_o, busy_o, neg_o, zero_o, dz_o}, 0);
  endtask

  task automatic t_narrow_unsigned();
    run_div(32'h0000_03E8, 16'h0007, 1'b0, 1'b0, 1'b0, "R1 1000/7");
    run_div(32'hABCD_1000, 16'hFF01, 1'b0, 1'b0, 1'b0, "R1 overflow");
    run_div(32'h0000_0005, 16'h0009, 1'b0, 1'b0, 1'b0, "R1 small");
    run_div(32'h0000_FFFF, 16'h00FF, 1'b0, 1'b0, 1'b0, "R1 all ones");
  endtask

  task automatic t_wide_unsigned();
    run_div(32'h1234_5678, 16'h0ABC, 1'b1, 1'b0, 1'b0, "R2 mixed");
    run_div(32'hFFFF_FFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R2 all ones");
    run_div(32'h0000_FFFE, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R2 q zero");
  endtask

  task automatic t_narrow_signed();
    run_div(32'h5555_FF9C, 16'h7707, 1'b0, 1'b1, 1'b0, "R3 R5 -100/7");
    run_div(32'h0000_0064, 16'h00F9, 1'b0, 1'b1, 1'b0, "R3 R5 100/-7");
    run_div(32'hFFFF_FF9C, 16'h00F9, 1'b0, 1'b1, 1'b0, "R3 R5 -100/-7");
    run_div(32'h0000_8000, 16'h00FF, 1'b0, 1'b1, 1'b0, "R3 min/-1");
    run_div(32'h0000_FFFD, 16'h0004, 1'b0, 1'b1, 1'b0, "R5 -3/4");
  endtask

  task automatic t_wide_signed();
    run_div(32'hFFF0_BDC0, 16'h0123, 1'b1, 1'b1, 1'b0, "R4 R5 neg/pos");
    run_div(32'h000F_4240, 16'hFF85, 1'b1, 1'b1, 1'b0, "R4 R5 pos/neg");
    run_div(32'h8000_0000, 16'h8000, 1'b1, 1'b1, 1'b0, "R4 min/min");
    run_div(32'h8000_0000, 16'hFFFF, 1'b1, 1'b1, 1'b0, "R4 min/-1");
  endtask

  task automatic t_div_zero();
    run_div(32'h0000_1234, 16'hAB00, 1'b0, 1'b1, 1'b0, "R8 narrow zero");
    run_div(32'h1234_5678, 16'h0000, 1'b1, 1'b0, 1'b0, "R8 wide zero");
    run_div(32'h0000_0011, 16'h0003, 1'b0, 1'b0, 1'b0, "R8 clear");
  endtask

  task automatic t_ignore_start();
    run_div(32'h0765_4321, 16'h0033, 1'b1, 1'b0, 1'b1, "R10 wide poke");
    run_div(32'h0000_C350, 16'h0011, 1'b0, 1'b1, 1'b1, "R10 narrow poke");
  endtask

  initial begin
    #200_000_0;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_narrow_unsigned();
    t_wide_unsigned();
    t_narrow_signed();
    t_wide_signed();
    t_div_zero();
    t_ignore_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule